// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits, by default 5, and returns a product of `2*WIDTH` bits. It works through the multiplier one bit per clock, least significant bit first. The multiplicand sits in a holding register. The partial product sits in an upper-half register, and the multiplier register holds the lower half of the result. On each step the multiplicand is added to the upper half only when the current multiplier bit is 1. The carry of that addition, the upper half and the lower half are then moved right by one place as a single chain.

A one-cycle `start_i` pulse, given while the unit is idle, captures both operands and clears the partial product. The unit then runs for exactly `WIDTH` steps, whatever the operand values are. A step counter loaded with `WIDTH` ends the run. On completion `done_o` pulses for one cycle. `product_o` then holds the result until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: While idle, a cycle with `start_i` high captures `mcand_i` and `mplier_i`, clears the partial product and loads the step counter with `WIDTH`; `busy_o` is high from the following cycle.
- R2: In each step, when bit 0 of the multiplier register is 1, the multiplicand is added to the upper half with a carry out; when it is 0, the upper half passes unchanged into the shift.
- R3: After the conditional add, the carry, the upper half and the lower half shift right by one together: the carry enters the top bit of the upper half, bit 0 of the upper half enters the top bit of the lower half, and the carry position becomes 0.
- R4: A run takes exactly `WIDTH` steps for any operand values, so `done_o` is high `WIDTH` clock edges after the edge that accepted the start.
- R5: `done_o` is high for exactly one cycle per run, and `busy_o` is low while `done_o` is high.
- R6: When `done_o` is high, `product_o` equals the unsigned product `mcand_i * mplier_i` (upper half in bits 2*WIDTH-1..WIDTH), and it stays unchanged until the next accepted start.
- R7: `start_i` is ignored while `busy_o` is high: the operands in progress, the result and the run length are unaffected.
- R8: A zero operand gives a zero product, and all ones times all ones gives (2^WIDTH-1)^2.
- R9: While `rst_n` is low, and directly after it, the unit is idle with `busy_o` = 0, `done_o` = 0 and `product_o` = 0, including when reset arrives during a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only while idle |
| mcand_i | input | WIDTH | Unsigned multiplicand |
| mplier_i | input | WIDTH | Unsigned multiplier |
| busy_o | output | 1 | High while steps are in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2*WIDTH | Upper half and lower half of the result |

## Verification
The assertions check the single step on every cycle. They cover the pass-through of the upper half when the multiplier bit is 0, the bit that crosses from the upper half into the lower half, and the countdown of the step counter from `WIDTH`. They also check that the multiplicand holds through a run and that `done_o` is a single pulse outside `busy_o`. Only the bench's scenarios can show that the whole chain of steps yields the correct product. The same applies to the total latency counted from the start edge, to a start during a run being ignored, to the result holding after completion, and to the zero and all-ones operand corners.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/mul_step_cnt.sv
module mul_step_cnt #(
  parameter int WIDTH = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  output logic last
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(WIDTH);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | step;
    cnt_d  = cnt_q;
    if (load)      cnt_d = CNT_INIT;
    else if (step) cnt_d = cnt_q - CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CNT_ONE);

  // R1: a load presets the count to the operand width
  p_cnt_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == CNT_INIT));

  // R4: each non-final step lowers the count by one
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last && !load) |=> (cnt_q == $past(cnt_q) - CNT_ONE));
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic last,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  mul_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    load    = (state_q == ST_IDLE) && start;
    step    = (state_q == ST_RUN);
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_RUN;
      ST_RUN: begin
        if (last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign busy = (state_q == ST_RUN);
  assign done = done_q;

  // R5: completion is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: completion never overlaps a run
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R1: an accepted start leads to a run
  p_start_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int WIDTH = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] product
);
  logic [WIDTH-1:0] b_q, b_d;
  logic [WIDTH-1:0] a_q, a_d;
  logic [WIDTH-1:0] q_q, q_d;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] sum;
  logic [WIDTH:0]   carry;
  logic             b_en, aq_en;

  assign addend   = b_q & {WIDTH{q_q[0]}};
  assign carry[0] = 1'b0;

  for (genvar g = 0; g < WIDTH; g++) begin : g_fa
    assign sum[g]     = a_q[g] ^ addend[g] ^ carry[g];
    assign carry[g+1] = (a_q[g] & addend[g]) | (carry[g] & (a_q[g] ^ addend[g]));
  end

  always_comb begin
    b_en  = load;
    aq_en = load | step;
    b_d   = mcand;
    if (load) begin
      a_d = '0;
      q_d = mplier;
    end else begin
      a_d = {carry[WIDTH], sum[WIDTH-1:1]};
      q_d = {sum[0], q_q[WIDTH-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    b_q <= '0;
    else if (b_en) b_q <= b_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      q_q <= '0;
    end else if (aq_en) begin
      a_q <= a_d;
      q_q <= q_d;
    end
  end

  assign product = {a_q, q_q};

  // R1: a load clears the upper half and captures the multiplier
  p_load_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (a_q == '0) && (q_q == $past(mplier)));

  // R2: with a zero multiplier bit the upper half is only shifted
  p_skip_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !q_q[0]) |=> (a_q == ($past(a_q) >> 1)));

  // R3: the bit crossing into the lower half is the low sum bit
  p_cross_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (q_q[WIDTH-1] == ($past(a_q[0]) ^ ($past(q_q[0]) & $past(b_q[0])))));

  // R7: the multiplicand stays put unless a start is accepted
  p_mcand_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(b_q));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int WIDTH = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  logic load, step, last;

  mul_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_i),
    .last  (last),
    .load  (load),
    .step  (step),
    .busy  (busy_o),
    .done  (done_o)
  );

  mul_step_cnt #(.WIDTH(WIDTH)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .last  (last)
  );

  mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .mcand   (mcand_i),
    .mplier  (mplier_i),
    .product (product_o)
  );

  // R6: the result is frozen while idle and no start arrives
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(product_o));
endmodule

// File: tb/test_shift_add_mul.sv
module test_shift_add_mul;
  localparam int W          = 5;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 10;

  // stimulus and expected product for W = 5
  localparam logic [W-1:0]   V_MC  [NVEC] = '{5'd3, 5'd0, 5'd31, 5'd31, 5'd13, 5'd1, 5'd16, 5'd21, 5'd7, 5'd30};
  localparam logic [W-1:0]   V_MP  [NVEC] = '{5'd5, 5'd31, 5'd0, 5'd31, 5'd11, 5'd1, 5'd2, 5'd10, 5'd25, 5'd17};
  localparam logic [2*W-1:0] V_EXP [NVEC] = '{10'd15, 10'd0, 10'd0, 10'd961, 10'd143, 10'd1, 10'd32, 10'd210, 10'd175, 10'd510};

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start_i;
  logic [W-1:0]   mcand_i, mplier_i;
  logic           busy_o, done_o;
  logic [2*W-1:0] product_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_add_mul #(.WIDTH(W)) i_shift_add_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // launch one run; optionally inject a start during the run (R7)
  task automatic run_one(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [2*W-1:0] exp, input bit poke);
    int cyc;
    @(negedge clk);
    mcand_i = a; mplier_i = b; start_i = 1'b1;
    @(negedge clk);                       // load edge has passed
    start_i = 1'b0;
    check("R1 busy after start", busy_o, 1);
    cyc = 0;
    while (!done_o && cyc < 4*W) begin
      if (poke && cyc == 1) begin
        mcand_i = '1; mplier_i = '1; start_i = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    check("R4 latency in steps", cyc, W);
    check("R6 product", product_o, exp);
    check("R5 busy low at done", busy_o, 0);
    @(negedge clk);
    check("R5 done single pulse", done_o, 0);
    @(negedge clk);
    check("R6 product held", product_o, exp);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b1; mcand_i = '1; mplier_i = '1;
    repeat (3) @(negedge clk);
    // R9: reset state, start held high during reset
    check("R9 busy in reset", busy_o, 0);
    check("R9 done in reset", done_o, 0);
    check("R9 product in reset", product_o, 0);
    start_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after release", busy_o, 0);

    // R2 R3 R6 R8: vector table walk (zero and all-ones rows cover R8)
    for (int i = 0; i < NVEC; i++) begin
      run_one(V_MC[i], V_MP[i], V_EXP[i], 1'b0);
    end

    // R7: start during a run is ignored
    run_one(5'd3, 5'd5, 10'd15, 1'b1);

    // R7: result unaffected by idle-time operand changes without start
    mcand_i = 5'd9; mplier_i = 5'd9;
    repeat (3) @(negedge clk);
    check("R7 no start no change", product_o, 15);

    // R9: reset during a run returns to idle with a cleared result
    @(negedge clk);
    mcand_i = 5'd31; mplier_i = 5'd31; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 busy after mid-run reset", busy_o, 0);
    check("R9 product after mid-run reset", product_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: back-to-back maximum operands after reset
    run_one(5'd31, 5'd31, 10'd961, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule